// File: doc/BRIEF.md
# Sequential Unsigned Divider with Selectable Restoring or Non-Restoring Iteration

This block divides an unsigned dividend by an unsigned divisor of the same width. It produces one quotient bit per clock. A partial-remainder register, one bit wider than the operands, sits to the left of a quotient register that starts out holding the dividend. The pair shifts left once per step. A divisor register stays fixed for the whole operation. On each step the datapath either subtracts the divisor or adds it, and the quotient bit that shifts in records the sign of the result.

A mode input, sampled with the start request, selects one of two algorithms:

- **Restoring mode** undoes a subtraction that went negative within the same step.
- **Non-restoring mode** lets the partial remainder go negative and corrects it with an add on the following step. It then spends one more cycle on a final corrective add before it reports.

A zero divisor does not iterate. It finishes at once and raises a flag. Results are registered and stay on the outputs until the next operation completes. A new request may be issued in the same cycle that the previous result is reported.

Top module: `seq_divider`

## Requirements
- R1: While reset is high and after it is released, `done_o`, `dbz_o`, `quotient_o` and `remainder_o` are all zero until the first operation finishes.
- R2: With `mode_i` = 0 (restoring) and a non-zero divisor, the result reports `quotient_o` = dividend / divisor and `remainder_o` = dividend mod divisor, for every operand pair.
- R3: With `mode_i` = 1 (non-restoring) and a non-zero divisor, the result is the same quotient and remainder. For 4-bit operands, 11 / 3 gives 3 remainder 2, and 13 / 3 gives 4 remainder 1.
- R4: Latency is counted in rising edges, starting with the edge that samples `start_i` and including it. The count until `done_o` is seen high is W+1 in restoring mode and W+2 in non-restoring mode.
- R5: A request with a zero divisor gives `done_o` and `dbz_o` high after exactly one edge. It reports `quotient_o` as all ones and `remainder_o` equal to the dividend. A completed non-zero division clears `dbz_o`.
- R6: `done_o` is high for one cycle per completed request. `quotient_o`, `remainder_o` and `dbz_o` hold their values until the next request completes.
- R7: A `start_i` that arrives while an operation is running is ignored. The running operation reports its own operands' result, and no extra completion follows.
- R8: A request issued in the cycle where `done_o` is high is accepted, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request; accepted when the block is idle |
| mode_i | input | 1 | 0 = restoring, 1 = non-restoring; sampled with the request |
| dividend_i | input | W | Unsigned dividend, sampled with the request |
| divisor_i | input | W | Unsigned divisor, sampled with the request |
| quotient_o | output | W | Registered quotient |
| remainder_o | output | W | Registered remainder |
| done_o | output | 1 | One-cycle completion strobe |
| dbz_o | output | 1 | Division by zero; valid with `done_o` |

## Verification
Result reporting and request acceptance can fall in the same cycle. The controller is back to idle while `done_o` is high, so a request seen in that cycle must be taken at once.

The driver issues nearly every request in the very cycle it observes `done_o`. It alternates runs of back-to-back requests with spaced ones. Each result is then judged for value and edge count, so a lost or delayed request shows up as a latency or value mismatch.

Zero-divisor requests finish one edge later. This places two completions on consecutive cycles, and neither may be merged into the other.

// File: rtl/seq_divider_pkg.sv
package seq_divider_pkg;

    typedef enum logic {
        MODE_RESTORE    = 1'b0,
        MODE_NONRESTORE = 1'b1
    } div_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    // Cycles from the accepting edge to the result edge
    function automatic int unsigned steps_for(input div_mode_e m, input int unsigned w);
        return (m == MODE_NONRESTORE) ? w + 1 : w;
    endfunction

endpackage

// File: rtl/div_step_unit.sv
module div_step_unit
    import seq_divider_pkg::*;
#(
    parameter int W = 4
) (
    input  div_mode_e    mode_i,
    input  logic [W:0]   part_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W:0]   part_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] shifted;
    logic [W:0] dvs_ext;
    logic [W:0] diff;
    logic [W:0] sum;
    logic       qbit;

    always_comb begin
        shifted = {part_i[W-1:0], quo_i[W-1]};
        dvs_ext = {1'b0, dvs_i};
        diff    = shifted - dvs_ext;
        sum     = shifted + dvs_ext;
        if (mode_i == MODE_NONRESTORE) begin
            // sign of previous partial remainder picks add or subtract
            part_o = part_i[W] ? sum : diff;
            qbit   = ~part_o[W];
        end else begin
            part_o = diff[W] ? shifted : diff;
            qbit   = ~diff[W];
        end
        quo_o = {quo_i[W-2:0], qbit};
    end
endmodule

// File: rtl/div_rem_fix.sv
module div_rem_fix #(
    parameter int W = 4
) (
    input  logic [W:0]   part_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o
);
    logic [W:0] fixed;

    always_comb begin
        fixed = part_i[W] ? (part_i + {1'b0, dvs_i}) : part_i;
        rem_o = fixed[W-1:0];
    end
endmodule

// File: rtl/div_seq_ctrl.sv
module div_seq_ctrl
    import seq_divider_pkg::*;
#(
    parameter int W = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      zero_div_i,
    input  div_mode_e mode_i,
    output logic      load_o,
    output logic      zero_fin_o,
    output logic      step_o,
    output logic      fix_o,
    output logic      finish_o,
    output logic      busy_o
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_e     state_q;
    logic [CW-1:0]  cnt_q;
    logic           accept;
    logic           last;

    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        accept     = !busy_o && start_i;
        load_o     = accept && !zero_div_i;
        zero_fin_o = accept && zero_div_i;
        step_o     = (state_q == ST_RUN);
        fix_o      = (state_q == ST_FIX);
        last       = step_o && (cnt_q == LAST);
        finish_o   = (last && mode_i == MODE_RESTORE) || fix_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (load_o) begin
                    state_q <= ST_RUN;
                    cnt_q   <= '0;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last)
                        state_q <= (mode_i == MODE_NONRESTORE) ? ST_FIX : ST_IDLE;
                end
                ST_FIX:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import seq_divider_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         mode_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quotient_o,
    output logic [W-1:0] remainder_o,
    output logic         done_o,
    output logic         dbz_o
);
    logic [W:0]   part_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] dvs_q;
    div_mode_e    mode_q;

    logic [W:0]   step_part;
    logic [W-1:0] step_quo;
    logic [W-1:0] fix_rem;
    logic         load, zero_fin, step_en, fix_en, finish, busy;

    logic [W-1:0] quot_r, rem_r;
    logic         done_r, dbz_r;

    div_seq_ctrl #(.W(W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .zero_div_i (divisor_i == '0),
        .mode_i     (mode_q),
        .load_o     (load),
        .zero_fin_o (zero_fin),
        .step_o     (step_en),
        .fix_o      (fix_en),
        .finish_o   (finish),
        .busy_o     (busy)
    );

    div_step_unit #(.W(W)) step_i (
        .mode_i (mode_q),
        .part_i (part_q),
        .quo_i  (quo_q),
        .dvs_i  (dvs_q),
        .part_o (step_part),
        .quo_o  (step_quo)
    );

    div_rem_fix #(.W(W)) fix_i (
        .part_i (part_q),
        .dvs_i  (dvs_q),
        .rem_o  (fix_rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            mode_q <= MODE_RESTORE;
            quot_r <= '0;
            rem_r  <= '0;
            done_r <= 1'b0;
            dbz_r  <= 1'b0;
        end else begin
            done_r <= finish || zero_fin;
            if (load) begin
                part_q <= '0;
                quo_q  <= dividend_i;
                dvs_q  <= divisor_i;
                mode_q <= div_mode_e'(mode_i);
            end else if (step_en) begin
                part_q <= step_part;
                quo_q  <= step_quo;
            end
            if (zero_fin) begin
                quot_r <= '1;
                rem_r  <= dividend_i;
                dbz_r  <= 1'b1;
            end else if (finish) begin
                quot_r <= step_en ? step_quo : quo_q;
                rem_r  <= step_en ? step_part[W-1:0] : fix_rem;
                dbz_r  <= 1'b0;
            end
        end
    end

    assign quotient_o  = quot_r;
    assign remainder_o = rem_r;
    assign done_o      = done_r;
    assign dbz_o       = dbz_r;
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic [W-1:0] dividend_i,
    input logic [W-1:0] divisor_i,
    input logic [W-1:0] quotient_o,
    input logic [W-1:0] remainder_o,
    input logic         done_o,
    input logic         dbz_o,
    input logic         busy,
    input logic         mode_bit,
    input logic         part_msb,
    input logic [W-1:0] dvs_q
);
    logic [W-1:0]   cap_dividend;
    logic [2*W-1:0] rebuilt;
    logic           zero_req;

    always_ff @(posedge clk) begin
        if (rst) cap_dividend <= '0;
        else if (start_i && !busy) cap_dividend <= dividend_i;
    end

    always_comb begin
        rebuilt  = ({{W{1'b0}}, quotient_o} * {{W{1'b0}}, dvs_q}) + {{W{1'b0}}, remainder_o};
        zero_req = start_i && !busy && (divisor_i == '0);
    end

    // R5: zero divisor finishes on the next cycle with the flag
    p_zero_div_r5: assert property (@(posedge clk) disable iff (rst)
        zero_req |=> (done_o && dbz_o && quotient_o == '1));

    // R6: completion strobe lasts one cycle unless a zero-divisor request follows
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (done_o && !zero_req) |=> !done_o);

    // R7: a request during a running operation leaves the divisor register alone
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i) |=> $stable(dvs_q));

    // R2: restoring mode never leaves a negative partial remainder in the register
    p_restore_nonneg_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !mode_bit) |-> !part_msb);

    // R3: every non-zero result satisfies q*d + r = n with r < d
    p_result_identity_r3: assert property (@(posedge clk) disable iff (rst)
        (done_o && !dbz_o) |-> (rebuilt == {{W{1'b0}}, cap_dividend} && remainder_o < dvs_q));
endmodule

bind seq_divider seq_divider_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .done_o      (done_o),
    .dbz_o       (dbz_o),
    .busy        (busy),
    .mode_bit    (mode_q),
    .part_msb    (part_q[W]),
    .dvs_q       (dvs_q)
);

// File: tb/seq_divider_tb_top.sv
module seq_divider_tb_top;
    localparam int W = 4;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         mode_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic [W-1:0] quotient_o, remainder_o;
    logic         done_o, dbz_o;

    always #2ns clk = ~clk;

    seq_divider #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .quotient_o(quotient_o), .remainder_o(remainder_o),
        .done_o(done_o), .dbz_o(dbz_o)
    );

    typedef struct {
        int    q;
        int    r;
        bit    dbz;
        int    lat;
        int    issued;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare whenever a completion is seen
    always @(negedge clk) begin
        if (!rst && done_o && !finished) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6/R7 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(quotient_o) == e.q, {e.tag, " quotient"}, int'(quotient_o), e.q);
                check(int'(remainder_o) == e.r, {e.tag, " remainder"}, int'(remainder_o), e.r);
                check(dbz_o == e.dbz, {e.tag, " dbz R5"}, int'(dbz_o), int'(e.dbz));
                check(cyc - e.issued == e.lat, "R4 latency", cyc - e.issued, e.lat);
            end
        end
    end

    // Driver: called at a negedge with the block idle or reporting
    task automatic issue(input int n, input int d, input bit md, input string tag);
        exp_t e;
        e.issued = cyc;
        e.tag = tag;
        if (d == 0) begin
            e.q = MAXV; e.r = n; e.dbz = 1'b1; e.lat = 1;
        end else begin
            e.q = n / d; e.r = n % d; e.dbz = 1'b0;
            e.lat = md ? W + 2 : W + 1;
        end
        exp_q.push_back(e);
        start_i    = 1'b1;
        mode_i     = md;
        dividend_i = W'(n);
        divisor_i  = W'(d);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check(done_o == 0 && dbz_o == 0 && quotient_o == 0 && remainder_o == 0,
              "R1 reset state", int'(quotient_o) + int'(remainder_o) + int'(done_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(done_o == 0 && quotient_o == 0 && remainder_o == 0,
              "R1 after reset", int'(quotient_o) + int'(done_o), 0);

        // R3: worked examples in non-restoring mode
        issue(11, 3, 1'b1, "R3 11/3");
        wait_done();
        @(negedge clk);
        issue(13, 3, 1'b1, "R3 13/3");
        wait_done();
        @(negedge clk);

        // R7: extra requests during a running operation are ignored
        issue(14, 4, 1'b0, "R7 busy-ignore");
        start_i = 1'b1; dividend_i = W'(5); divisor_i = W'(0);
        @(negedge clk);
        start_i = 1'b1; dividend_i = W'(9); divisor_i = W'(2); mode_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        @(negedge clk);

        // R6: result holds and strobe drops while idle
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R6 strobe low when idle", int'(done_o), 0);
        check(quotient_o == W'(3) && remainder_o == W'(2), "R6 result held",
              int'(quotient_o), 3);

        // R2 R3 R5 R8: exhaustive, mostly back-to-back
        for (int md = 0; md < 2; md++) begin
            for (int n = 0; n <= MAXV; n++) begin
                for (int d = 0; d <= MAXV; d++) begin
                    string tg;
                    tg = (d == 0) ? "R5 zero divisor" : (md == 1 ? "R3 non-restoring" : "R2 restoring");
                    if (((n + d) % 5) == 0) @(negedge clk);
                    issue(n, d, md[0], {tg, " R8"});
                    wait_done();
                end
            end
        end
        @(negedge clk);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R6 all results reported", exp_q.size(), 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule